// File: doc/BRIEF.md
# Serial-Addressed Row/Column ROM

This block is a small fixed-content memory with a bit-serial interface on both sides. An 8-bit address arrives one bit per phase pair, least significant bit first, into a serial-in shift register. An address strobe copies the assembled address into a hold register. The upper five bits of the held address pick one of 32 matrix rows, and the lower three bits pick one of eight 10-bit column groups on the selected row. A load strobe then moves the chosen 10-bit word into a parallel-in serial-out register, which presents it one bit per phase pair, least significant bit first, with a valid flag.

Every storage stage is a master/slave pair. The master takes new data in cycles where `phi1` is high and the slave copies the master in cycles where `phi2` is high, so a register moves by one position per `phi1`/`phi2` pair. Both phases are enables qualified by a single `clk`. A stage-wide set line forces the address and output registers to all ones, and an asynchronous active-low reset clears all state.

Top module: `serial_rom`

## Requirements
- R1: `phi1` and `phi2` are never high in the same cycle. Master latches change only in cycles with `phi1` high and slave latches change only in cycles with `phi2` high, so no output moves in a cycle without `phi2`.
- R2: In a pair where `addr_shift` is high at `phi1`, the address register takes `addr_bit` and shifts by one position. Bits are sent least significant first, so after eight such pairs the first bit sent is address bit 0. In a pair where `addr_shift` is low, the address register keeps its value.
- R3: Held address bits [7:3] select the row (0 to 31) and bits [2:0] select the column group (0 to 7). The selected word is the table entry at index row*8+column.
- R4: A pair with `addr_strobe` high at `phi1` copies the address register into the hold register. Later shifting without a strobe does not change which word is selected.
- R5: A pair with `word_load` high at `phi1` (and `preset` low) loads the selected word into the output register. `ser_out` shows word bit 0 after that pair and bit k after k further pairs. `ser_out_n` is always the inverse of `ser_out`.
- R6: `ser_valid` is high for exactly 10 pairs after a load, and the output register then shows zero. Zeros shift in from the top.
- R7: Reset clears the address, hold and output registers and the bit counter. After reset, `ser_out`=0, `ser_out_n`=1 and `ser_valid`=0, and a load with no strobe delivers the word at index 0.
- R8: A pair with `preset` high at `phi1` sets the address and output registers to all ones and ignores shift and load in that pair. `ser_out` then reads 1 and `ser_out_n` reads 0, and a following strobe plus load delivers the word at index 255.
- R9: The table entry at index a is ((a*93+321) mod 1024) XOR ((a*4) mod 1024).
- R10: A load while a word is still shifting out restarts the output with the newly selected word and a fresh 10-pair valid window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that qualifies both phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi1 | input | 1 | Phase one: masters capture |
| phi2 | input | 1 | Phase two: slaves copy masters |
| addr_bit | input | 1 | Serial address input, least significant bit first |
| addr_shift | input | 1 | Shift the address register this pair |
| addr_strobe | input | 1 | Copy the address register into the hold register |
| word_load | input | 1 | Load the selected word into the output register |
| preset | input | 1 | Set the address and output registers to all ones |
| ser_out | output | 1 | Serial data out, least significant bit first |
| ser_out_n | output | 1 | Inverse of ser_out |
| ser_valid | output | 1 | High while the 10 word bits are presented |

## Verification
A wrong bit in the address or hold register shows up as a whole wrong 10-bit word at the next load. It appears within 10 pairs of that load, because every output word is compared against the table. A decode fault that picks the wrong row or column gives the same result, so addresses are chosen to flip each row and column bit. A fault in the bit counter or the shift path shows in the length of the valid window or in a non-zero tail within one or two pairs. A master/slave ordering fault changes `ser_out` in a cycle without `phi2` and is caught in that same cycle.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int SROM_ADDR_W = 8;
  localparam int SROM_COL_W  = 3;
  localparam int SROM_WORD_W = 10;

  // table content before truncation to the word width
  function automatic logic [31:0] srom_cell(input int unsigned a);
    logic [31:0] m;
    logic [31:0] s;
    m = a * 32'd93 + 32'd321;
    s = a << 2;
    return m ^ s;
  endfunction
endpackage

// File: rtl/srom_tp_cell.sv
module srom_tp_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic phi1,
  input  logic phi2,
  input  logic d,
  input  logic cap,
  input  logic set,
  output logic m_q,
  output logic s_q,
  output logic s_qn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= 1'b0;
    end else if (phi1) begin
      if (set)      m_q <= 1'b1;
      else if (cap) m_q <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= 1'b0;
    else if (phi2) s_q <= m_q;
  end

  assign s_qn = ~s_q;
endmodule

// File: rtl/srom_tp_bank.sv
module srom_tp_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phi1,
  input  logic         phi2,
  input  logic [W-1:0] d,
  input  logic         cap,
  input  logic         set,
  output logic [W-1:0] m_q,
  output logic [W-1:0] s_q,
  output logic [W-1:0] s_qn
);
  for (genvar k = 0; k < W; k++) begin : g_cell
    srom_tp_cell u_cell (
      .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
      .d(d[k]), .cap(cap), .set(set),
      .m_q(m_q[k]), .s_q(s_q[k]), .s_qn(s_qn[k])
    );
  end
endmodule

// File: rtl/srom_addr_sipo.sv
module srom_addr_sipo #(
  parameter int ADDR_W = srom_pkg::SROM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi1,
  input  logic              phi2,
  input  logic              bit_in,
  input  logic              shift_en,
  input  logic              strobe,
  input  logic              preset,
  output logic [ADDR_W-1:0] sh_q,
  output logic [ADDR_W-1:0] sh_m,
  output logic [ADDR_W-1:0] hold_q,
  output logic              strobe_m
);
  logic [ADDR_W-1:0] sh_d;
  logic [ADDR_W-1:0] sh_qn;
  logic [ADDR_W-1:0] hold_m;
  logic [ADDR_W-1:0] hold_qn;
  logic              strobe_q;
  logic              strobe_qn;

  // new bit enters at the top stage and moves toward stage 0
  always_comb begin
    sh_d[ADDR_W-1] = bit_in;
    for (int k = 0; k < ADDR_W - 1; k++) sh_d[k] = sh_q[k+1];
  end

  srom_tp_bank #(.W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(sh_d), .cap(shift_en), .set(preset),
    .m_q(sh_m), .s_q(sh_q), .s_qn(sh_qn)
  );

  srom_tp_bank #(.W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(sh_q), .cap(strobe), .set(1'b0),
    .m_q(hold_m), .s_q(hold_q), .s_qn(hold_qn)
  );

  // strobe event as seen in the master domain
  srom_tp_cell u_strobe (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(strobe), .cap(1'b1), .set(1'b0),
    .m_q(strobe_m), .s_q(strobe_q), .s_qn(strobe_qn)
  );
endmodule

// File: rtl/srom_matrix.sv
module srom_matrix #(
  parameter int ADDR_W = srom_pkg::SROM_ADDR_W,
  parameter int COL_W  = srom_pkg::SROM_COL_W,
  parameter int WORD_W = srom_pkg::SROM_WORD_W
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic [WORD_W-1:0]         word,
  output logic [(1<<(ADDR_W-COL_W))-1:0] row_sel,
  output logic [(1<<COL_W)-1:0]     col_sel
);
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int LINE_W = COLS * WORD_W;

  function automatic logic [LINE_W-1:0] row_bits(input int unsigned r);
    logic [LINE_W-1:0] v;
    logic [31:0]       c;
    v = '0;
    for (int unsigned k = 0; k < COLS; k++) begin
      c = srom_pkg::srom_cell(r * COLS + k);
      v[k*WORD_W +: WORD_W] = c[WORD_W-1:0];
    end
    return v;
  endfunction

  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [LINE_W-1:0] row_line [ROWS];
  logic [LINE_W-1:0] bitline;

  assign row_idx = addr[ADDR_W-1:COL_W];
  assign col_idx = addr[COL_W-1:0];

  always_comb begin
    for (int r = 0; r < ROWS; r++) row_sel[r] = (row_idx == ROW_W'(r));
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) col_sel[c] = (col_idx == COL_W'(c));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [LINE_W-1:0] ROW_CONST = row_bits(r);
    assign row_line[r] = row_sel[r] ? ROW_CONST : '0;
  end

  always_comb begin
    bitline = '0;
    for (int r = 0; r < ROWS; r++) bitline = bitline | row_line[r];
  end

  always_comb begin
    word = '0;
    for (int c = 0; c < COLS; c++)
      if (col_sel[c]) word = word | bitline[c*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/srom_word_piso.sv
module srom_word_piso #(
  parameter int WORD_W = srom_pkg::SROM_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi1,
  input  logic              phi2,
  input  logic              load,
  input  logic              preset,
  input  logic [WORD_W-1:0] word_in,
  output logic              bit_out,
  output logic              bit_out_n,
  output logic              valid,
  output logic              load_m,
  output logic [WORD_W-1:0] out_q,
  output logic [$clog2(WORD_W+1)-1:0] cnt_q
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              eff_load;
  logic              busy;
  logic [WORD_W-1:0] sh_d;
  logic [WORD_W-1:0] out_m;
  logic [WORD_W-1:0] out_qn;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  cnt_m;
  logic [CNT_W-1:0]  cnt_qn;
  logic              load_q;
  logic              load_qn;

  assign eff_load = load & ~preset;
  assign busy     = (cnt_q != '0);

  always_comb begin
    for (int k = 0; k < WORD_W; k++) begin
      if (eff_load)            sh_d[k] = word_in[k];
      else if (k == WORD_W - 1) sh_d[k] = 1'b0;
      else                     sh_d[k] = out_q[k+1];
    end
  end

  assign cnt_d = eff_load ? CNT_W'(WORD_W) : cnt_q - CNT_W'(1);

  srom_tp_bank #(.W(WORD_W)) u_data (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(sh_d), .cap(eff_load | busy), .set(preset),
    .m_q(out_m), .s_q(out_q), .s_qn(out_qn)
  );

  srom_tp_bank #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(cnt_d), .cap(eff_load | busy), .set(1'b0),
    .m_q(cnt_m), .s_q(cnt_q), .s_qn(cnt_qn)
  );

  srom_tp_cell u_load (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .d(eff_load), .cap(1'b1), .set(1'b0),
    .m_q(load_m), .s_q(load_q), .s_qn(load_qn)
  );

  assign bit_out   = out_q[0];
  assign bit_out_n = out_qn[0];
  assign valid     = busy;
endmodule

// File: rtl/serial_rom.sv
module serial_rom #(
  parameter int ADDR_W = srom_pkg::SROM_ADDR_W,
  parameter int COL_W  = srom_pkg::SROM_COL_W,
  parameter int WORD_W = srom_pkg::SROM_WORD_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi1,
  input  logic phi2,
  input  logic addr_bit,
  input  logic addr_shift,
  input  logic addr_strobe,
  input  logic word_load,
  input  logic preset,
  output logic ser_out,
  output logic ser_out_n,
  output logic ser_valid
);
  localparam int ROWS  = 1 << (ADDR_W - COL_W);
  localparam int COLS  = 1 << COL_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  // named internal events for the checker
  logic [ADDR_W-1:0] addr_sh_q;
  logic [ADDR_W-1:0] addr_sh_m;
  logic [ADDR_W-1:0] addr_hold;
  logic              strobe_evt;
  logic [WORD_W-1:0] sel_word;
  logic [ROWS-1:0]   row_sel;
  logic [COLS-1:0]   col_sel;
  logic              load_evt;
  logic [WORD_W-1:0] out_reg;
  logic [CNT_W-1:0]  bit_cnt;

  srom_addr_sipo #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .bit_in(addr_bit), .shift_en(addr_shift), .strobe(addr_strobe),
    .preset(preset), .sh_q(addr_sh_q), .sh_m(addr_sh_m),
    .hold_q(addr_hold), .strobe_m(strobe_evt)
  );

  srom_matrix #(.ADDR_W(ADDR_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_matrix (
    .addr(addr_hold), .word(sel_word), .row_sel(row_sel), .col_sel(col_sel)
  );

  srom_word_piso #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .load(word_load), .preset(preset), .word_in(sel_word),
    .bit_out(ser_out), .bit_out_n(ser_out_n), .valid(ser_valid),
    .load_m(load_evt), .out_q(out_reg), .cnt_q(bit_cnt)
  );
endmodule

// File: rtl/serial_rom_chk.sv
module serial_rom_chk #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 10,
  parameter int ROWS   = 32,
  parameter int COLS   = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi1,
  input logic              phi2,
  input logic              ser_out,
  input logic [ADDR_W-1:0] addr_sh_q,
  input logic [ADDR_W-1:0] addr_sh_m,
  input logic [ADDR_W-1:0] addr_hold,
  input logic              strobe_evt,
  input logic [WORD_W-1:0] sel_word,
  input logic [ROWS-1:0]   row_sel,
  input logic [COLS-1:0]   col_sel,
  input logic              load_evt,
  input logic [WORD_W-1:0] out_reg,
  input logic [CNT_W-1:0]  bit_cnt
);
  p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  p_slave_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |=> ($stable(addr_sh_q) && $stable(out_reg) && $stable(ser_out)));

  p_master_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi1 |=> $stable(addr_sh_m));

  p_decode_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(row_sel) == 1) && ($countones(col_sel) == 1));

  p_hold_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && strobe_evt) |=> (addr_hold == $past(addr_sh_q)));

  p_load_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && load_evt) |=> (out_reg == $past(sel_word)));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  p_count_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && load_evt) |=> (bit_cnt == CNT_W'(WORD_W)));
endmodule

bind serial_rom serial_rom_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .ser_out(ser_out),
  .addr_sh_q(addr_sh_q), .addr_sh_m(addr_sh_m), .addr_hold(addr_hold),
  .strobe_evt(strobe_evt), .sel_word(sel_word), .row_sel(row_sel),
  .col_sel(col_sel), .load_evt(load_evt), .out_reg(out_reg), .bit_cnt(bit_cnt)
);

// File: tb/test_serial_rom.sv
module test_serial_rom;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi1 = 1'b0, phi2 = 1'b0;
  logic addr_bit = 1'b0, addr_shift = 1'b0, addr_strobe = 1'b0;
  logic word_load = 1'b0, preset = 1'b0;
  logic ser_out, ser_out_n, ser_valid;
  int   total = 0;
  int   bad = 0;

  always #10 clk = ~clk;

  serial_rom i_serial_rom (
    .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
    .addr_bit(addr_bit), .addr_shift(addr_shift), .addr_strobe(addr_strobe),
    .word_load(word_load), .preset(preset),
    .ser_out(ser_out), .ser_out_n(ser_out_n), .ser_valid(ser_valid)
  );

  function automatic int exp_word(input int a);
    return ((a * 93 + 321) % 1024) ^ ((a * 4) % 1024);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_pair();
    @(negedge clk) phi1 = 1'b1;
    @(negedge clk) begin phi1 = 1'b0; phi2 = 1'b1; end
    @(negedge clk) phi2 = 1'b0;
  endtask

  task automatic shift_addr(input int a);
    for (int i = 0; i < 8; i++) begin
      addr_bit = a[i];
      addr_shift = 1'b1;
      do_pair();
    end
    addr_shift = 1'b0;
    addr_bit = 1'b0;
  endtask

  task automatic strobe();
    addr_strobe = 1'b1;
    do_pair();
    addr_strobe = 1'b0;
  endtask

  // load, then collect bits while valid; returns word, valid length, inverse errors
  task automatic read_out(output int word, output int len, output int inv_err);
    word = 0; len = 0; inv_err = 0;
    word_load = 1'b1;
    do_pair();
    word_load = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (!ser_valid) break;
      if (ser_out_n != ~ser_out) inv_err++;
      if (len < 10) word = word | (int'(ser_out) << len);
      len++;
      do_pair();
    end
  endtask

  task automatic t_reset();
    int w, l, e;
    check("R7 ser_out after reset", ser_out, 0);
    check("R7 ser_out_n after reset", ser_out_n, 1);
    check("R7 ser_valid after reset", ser_valid, 0);
    read_out(w, l, e);
    check("R7 word at index 0 without strobe", w, exp_word(0));
  endtask

  task automatic t_word(input int a);
    int w, l, e;
    shift_addr(a);
    strobe();
    read_out(w, l, e);
    check($sformatf("R3 R9 word at address %0h", a), w, exp_word(a));
    check("R6 valid window length", l, 10);
    check("R6 zero tail after shift", ser_out, 0);
    check("R5 ser_out_n inverse", e, 0);
  endtask

  task automatic t_hold();
    int w, l, e;
    shift_addr(8'h6D);
    strobe();
    shift_addr(8'h92);
    read_out(w, l, e);
    check("R4 held address kept after reshift", w, exp_word(8'h6D));
  endtask

  task automatic t_noshift();
    int w, l, e;
    shift_addr(8'hC3);
    addr_shift = 1'b0;
    for (int i = 0; i < 3; i++) begin
      addr_bit = ~addr_bit;
      do_pair();
    end
    addr_bit = 1'b0;
    strobe();
    read_out(w, l, e);
    check("R2 address unchanged without shift enable", w, exp_word(8'hC3));
  endtask

  task automatic t_phases();
    int a;
    int v0;
    a = 8'h3B;
    shift_addr(a);
    strobe();
    word_load = 1'b1;
    do_pair();
    word_load = 1'b0;
    v0 = exp_word(a);
    check("R5 first bit after load", ser_out, v0 & 1);
    repeat (4) @(negedge clk);
    check("R1 output still without phases", ser_out, v0 & 1);
    check("R1 valid still without phases", ser_valid, 1);
    @(negedge clk) phi1 = 1'b1;
    @(negedge clk) phi1 = 1'b0;
    check("R1 output still after phi1 alone", ser_out, v0 & 1);
    @(negedge clk) phi2 = 1'b1;
    @(negedge clk) phi2 = 1'b0;
    check("R1 R5 second bit after phi2", ser_out, (v0 >> 1) & 1);
    for (int i = 0; i < 12; i++) begin
      if (!ser_valid) break;
      do_pair();
    end
  endtask

  task automatic t_preset();
    int w, l, e;
    preset = 1'b1;
    word_load = 1'b1;
    do_pair();
    preset = 1'b0;
    word_load = 1'b0;
    check("R8 ser_out set", ser_out, 1);
    check("R8 ser_out_n set", ser_out_n, 0);
    check("R8 load ignored under preset", ser_valid, 0);
    strobe();
    read_out(w, l, e);
    check("R8 preset address gives index 255", w, exp_word(255));
  endtask

  task automatic t_restart();
    int w, l, e;
    shift_addr(8'h14);
    strobe();
    shift_addr(8'hE7);
    word_load = 1'b1;
    do_pair();
    word_load = 1'b0;
    do_pair();
    do_pair();
    do_pair();
    strobe();
    read_out(w, l, e);
    check("R10 restart delivers new word", w, exp_word(8'hE7));
    check("R10 restart valid length", l, 10);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word(8'h00);
    t_word(8'hFF);
    t_word(8'h5A);
    t_word(8'h81);
    t_word(8'h07);
    t_word(8'hF8);
    t_hold();
    t_noshift();
    t_phases();
    t_preset();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule